// File: doc/BRIEF.md
# USB Endpoint Control with DMA Gating

This block keeps the control state of one endpoint in a USB device controller. Software changes each control bit through a pair of one-cycle strobes, one to set it and one to clear it. Alongside those bits the block tracks which packet bank software currently owns, with one bank or two alternating banks, and the DATA0/DATA1 toggle. It also holds a request to answer the host with a STALL handshake.

The block also gates the endpoint's DMA request. When DMA pausing is enabled, every endpoint interrupt event withholds the request, whether or not that interrupt is enabled at the endpoint. An event that reports a new packet in a bank lets a transfer already under way finish, then raises no request for the new bank. An event with no packet behind it, such as a NAK, withdraws the request at once, even in the middle of a transfer. The request comes back when software acknowledges the interrupt source or turns pausing off.

Top module: `usb_ep_ctl_gate`

## Requirements
- R1: After reset the current bank is 0, the toggle is DATA0 (0), STALL request and DMA pause are off, no interrupt is pending, and `dma_req` equals `dma_want`.
- R2: `pause_set` turns DMA pause on and `pause_clr` turns it off. `stall_set` and `stall_clr` do the same for the STALL request. With every strobe at 0 a bit keeps its value, and when set and clear arrive together the set wins.
- R3: With `pingpong_en`=1, each `fifo_clr` pulse frees the current bank and moves `cur_bank` to the other bank (modulo 2). With `pingpong_en`=0, `cur_bank` is always 0.
- R4: While pause is on, an `ev_nak` pulse drops `dma_req` in the next cycle even while `dma_busy`=1, whatever the value of `irq_en`.
- R5: While pause is on, an `ev_bank_rx` pulse leaves `dma_req` high as long as `dma_busy`=1. `dma_req` falls in the first cycle `dma_busy` is 0.
- R6: A withheld request returns in the cycle after `irq_ack` or after `pause_clr`.
- R7: While pause is off, events never affect `dma_req`, and `dma_req` equals `dma_want`.
- R8: `rstdt_set` forces the toggle to DATA0 for the next packet. This takes priority over `ev_pkt_ok` in the same cycle. The strobe leaves no bit behind that stays set.
- R9: The toggle inverts after each `ev_pkt_ok` and holds through `ev_nak` and through cycles with no event.
- R10: `ev_setup` clears the STALL request. A `stall_set` in the same cycle wins and leaves it set.
- R11: `ev_bank_rx` or `ev_nak` marks an interrupt pending, and `irq_ack` clears it, with a new event winning over an acknowledge in the same cycle. `ep_irq` is the pending mark gated by `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pingpong_en | input | 1 | 1 = two alternating banks, 0 = single bank |
| irq_en | input | 1 | Endpoint interrupt enable |
| fifo_clr | input | 1 | Strobe: free current bank, advance pointer |
| pause_set | input | 1 | Strobe: enable DMA pause |
| pause_clr | input | 1 | Strobe: disable DMA pause |
| stall_set | input | 1 | Strobe: request STALL |
| stall_clr | input | 1 | Strobe: withdraw STALL |
| rstdt_set | input | 1 | Strobe: force toggle to DATA0 |
| ev_bank_rx | input | 1 | Event: packet stored in a new bank |
| ev_nak | input | 1 | Event: NAK sent or received (no new bank) |
| ev_setup | input | 1 | Event: SETUP packet received |
| ev_pkt_ok | input | 1 | Event: packet completed successfully |
| irq_ack | input | 1 | Software acknowledges interrupt source |
| dma_want | input | 1 | DMA would be requested without gating |
| dma_busy | input | 1 | A DMA transfer is in flight |
| pause_en | output | 1 | DMA pause enable bit |
| stall_req | output | 1 | STALL request bit |
| cur_bank | output | 1 | Bank currently owned by software |
| toggle | output | 1 | Data toggle for next packet (0 = DATA0) |
| ep_irq | output | 1 | Endpoint interrupt |
| dma_req | output | 1 | Gated DMA request |

## Verification
Two pairs of functions can act in the same cycle. A SETUP arrival can coincide with a software STALL set, and a reset-toggle strobe can coincide with a completed packet. The bench drives each pair in one cycle and expects the software set and the DATA0 force to win. It also sends a bank event and an acknowledge in one cycle and expects the event to win. Beyond those collisions, it holds `dma_busy` high across a bank event and a NAK event, and checks that the request survives the first until the transfer ends but drops at once for the second.

// File: rtl/usb_ep_ctl_pkg.sv
package usb_ep_ctl_pkg;

  // Set has priority over any clear source.
  function automatic logic f_set_clr(input logic q, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return q;
  endfunction

  // Bank pointer advance, modulo the bank count; single-bank mode pins to 0.
  function automatic int unsigned f_next_bank(input int unsigned cur, input int unsigned nbank,
                                              input logic pp, input logic adv);
    if (!pp) return 0;
    if (adv) return (cur + 1) % nbank;
    return cur;
  endfunction

  // Toggle: forced DATA0 first, then flip on a good packet.
  function automatic logic f_next_toggle(input logic q, input logic force0, input logic flip);
    if (force0) return 1'b0;
    if (flip) return ~q;
    return q;
  endfunction

  // DMA block decision from pause state, pending kinds and transfer status.
  function automatic logic f_dma_block(input logic pause, input logic pend_hard,
                                       input logic pend_bank, input logic busy);
    return pause && (pend_hard || (pend_bank && !busy));
  endfunction

endpackage

// File: rtl/ep_ctl_bit.sv
module ep_ctl_bit
  import usb_ep_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= f_set_clr(q_o, set_i, clr_i);
  end
endmodule

// File: rtl/ep_bank_toggle.sv
module ep_bank_toggle
  import usb_ep_ctl_pkg::*;
#(
  parameter int unsigned NBANK  = 2,
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pingpong_en,
  input  logic              bank_adv,
  input  logic              tog_force0,
  input  logic              tog_flip,
  output logic [BANK_W-1:0] bank_o,
  output logic              toggle_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_o   <= '0;
      toggle_o <= 1'b0;
    end else begin
      bank_o   <= BANK_W'(f_next_bank(int'(bank_o), NBANK, pingpong_en, bank_adv));
      toggle_o <= f_next_toggle(toggle_o, tog_force0, tog_flip);
    end
  end
endmodule

// File: rtl/ep_dma_gate.sv
module ep_dma_gate
  import usb_ep_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pause,
  input  logic ev_bank,
  input  logic ev_hard,
  input  logic ack,
  input  logic busy,
  input  logic want,
  output logic pend_bank_o,
  output logic pend_hard_o,
  output logic block_o,
  output logic req_o
);
  // Events win over an acknowledge in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_bank_o <= 1'b0;
      pend_hard_o <= 1'b0;
    end else begin
      pend_bank_o <= f_set_clr(pend_bank_o, ev_bank, ack);
      pend_hard_o <= f_set_clr(pend_hard_o, ev_hard, ack);
    end
  end

  always_comb begin
    block_o = f_dma_block(pause, pend_hard_o, pend_bank_o, busy);
    req_o   = want && !block_o;
  end
endmodule

// File: rtl/usb_ep_ctl_gate.sv
module usb_ep_ctl_gate
  import usb_ep_ctl_pkg::*;
#(
  parameter int unsigned NBANK  = 2,
  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pingpong_en,
  input  logic              irq_en,
  input  logic              fifo_clr,
  input  logic              pause_set,
  input  logic              pause_clr,
  input  logic              stall_set,
  input  logic              stall_clr,
  input  logic              rstdt_set,
  input  logic              ev_bank_rx,
  input  logic              ev_nak,
  input  logic              ev_setup,
  input  logic              ev_pkt_ok,
  input  logic              irq_ack,
  input  logic              dma_want,
  input  logic              dma_busy,
  output logic              pause_en,
  output logic              stall_req,
  output logic [BANK_W-1:0] cur_bank,
  output logic              toggle,
  output logic              ep_irq,
  output logic              dma_req
);
  // Named internal events for the checker.
  logic w_stall_hw_clr;
  logic w_stall_clr_any;
  logic w_pend_bank;
  logic w_pend_hard;
  logic w_dma_block;

  assign w_stall_hw_clr  = ev_setup;
  assign w_stall_clr_any = stall_clr || w_stall_hw_clr;

  ep_ctl_bit u_pause (
    .clk(clk), .rst_n(rst_n), .set_i(pause_set), .clr_i(pause_clr), .q_o(pause_en)
  );

  ep_ctl_bit u_stall (
    .clk(clk), .rst_n(rst_n), .set_i(stall_set), .clr_i(w_stall_clr_any), .q_o(stall_req)
  );

  ep_bank_toggle #(.NBANK(NBANK)) u_bank_tog (
    .clk(clk), .rst_n(rst_n), .pingpong_en(pingpong_en), .bank_adv(fifo_clr),
    .tog_force0(rstdt_set), .tog_flip(ev_pkt_ok), .bank_o(cur_bank), .toggle_o(toggle)
  );

  ep_dma_gate u_gate (
    .clk(clk), .rst_n(rst_n), .pause(pause_en), .ev_bank(ev_bank_rx), .ev_hard(ev_nak),
    .ack(irq_ack), .busy(dma_busy), .want(dma_want),
    .pend_bank_o(w_pend_bank), .pend_hard_o(w_pend_hard),
    .block_o(w_dma_block), .req_o(dma_req)
  );

  assign ep_irq = (w_pend_bank || w_pend_hard) && irq_en;
endmodule

// File: rtl/usb_ep_ctl_gate_chk.sv
module usb_ep_ctl_gate_chk #(
  parameter int unsigned BANK_W = 1
)(
  input logic              clk,
  input logic              rst_n,
  input logic              pingpong_en,
  input logic              fifo_clr,
  input logic              pause_en,
  input logic              pause_clr,
  input logic              stall_set,
  input logic              stall_req,
  input logic              ev_setup,
  input logic              rstdt_set,
  input logic              ev_nak,
  input logic              dma_want,
  input logic              dma_req,
  input logic [BANK_W-1:0] cur_bank,
  input logic              toggle
);
  // R3: ping-pong advance moves the pointer
  a_r3_bank_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr && pingpong_en && $past(pingpong_en)) |=> (cur_bank != $past(cur_bank)));
  // R3: single bank mode holds bank 0
  a_r3_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (!pingpong_en) |=> (cur_bank == '0));
  // R10: software set beats SETUP clear
  a_r10_stall_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stall_set |=> stall_req);
  // R10: SETUP clears STALL
  a_r10_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_setup && !stall_set) |=> !stall_req);
  // R8: toggle reset to DATA0
  a_r8_rstdt_data0: assert property (@(posedge clk) disable iff (!rst_n)
    rstdt_set |=> !toggle);
  // R4: NAK under pause drops request
  a_r4_nak_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_en && ev_nak && !pause_clr) |=> !dma_req);
  // R7: pause off leaves request ungated
  a_r7_no_pause_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_en) |-> (dma_req == dma_want));
endmodule

bind usb_ep_ctl_gate usb_ep_ctl_gate_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pingpong_en(pingpong_en), .fifo_clr(fifo_clr),
  .pause_en(pause_en), .pause_clr(pause_clr), .stall_set(stall_set), .stall_req(stall_req),
  .ev_setup(ev_setup), .rstdt_set(rstdt_set), .ev_nak(ev_nak), .dma_want(dma_want),
  .dma_req(dma_req), .cur_bank(cur_bank), .toggle(toggle)
);

// File: tb/usb_ep_ctl_gate_tb.sv
module usb_ep_ctl_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pingpong_en = 1'b0, irq_en = 1'b0;
  logic fifo_clr = 0, pause_set = 0, pause_clr = 0, stall_set = 0, stall_clr = 0;
  logic rstdt_set = 0, ev_bank_rx = 0, ev_nak = 0, ev_setup = 0, ev_pkt_ok = 0, irq_ack = 0;
  logic dma_want = 1'b0, dma_busy = 1'b0;
  logic pause_en, stall_req, toggle, ep_irq, dma_req;
  logic [0:0] cur_bank;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_ctl_gate u_dut (
    .clk(clk), .rst_n(rst_n), .pingpong_en(pingpong_en), .irq_en(irq_en),
    .fifo_clr(fifo_clr), .pause_set(pause_set), .pause_clr(pause_clr),
    .stall_set(stall_set), .stall_clr(stall_clr), .rstdt_set(rstdt_set),
    .ev_bank_rx(ev_bank_rx), .ev_nak(ev_nak), .ev_setup(ev_setup), .ev_pkt_ok(ev_pkt_ok),
    .irq_ack(irq_ack), .dma_want(dma_want), .dma_busy(dma_busy),
    .pause_en(pause_en), .stall_req(stall_req), .cur_bank(cur_bank), .toggle(toggle),
    .ep_irq(ep_irq), .dma_req(dma_req)
  );

  typedef struct {
    string tag;
    logic  bank, tog, stall, pause, irq, dma;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0, failures = 0;

  // Bench's own view of the endpoint.
  logic m_bank = 0, m_tog = 0, m_stall = 0, m_pause = 0, m_pb = 0, m_ph = 0;

  task automatic chk1(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
    end
  endtask

  // Monitor: compares outputs shortly after each edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk1(e.tag, "cur_bank", cur_bank[0], e.bank);
      chk1(e.tag, "toggle", toggle, e.tog);
      chk1(e.tag, "stall_req", stall_req, e.stall);
      chk1(e.tag, "pause_en", pause_en, e.pause);
      chk1(e.tag, "ep_irq", ep_irq, e.irq);
      chk1(e.tag, "dma_req", dma_req, e.dma);
    end
  end

  // Driver: called just after a falling edge with strobes already set.
  task automatic cycle(input string tag);
    exp_t e;
    if (stall_set) m_stall = 1; else if (stall_clr || ev_setup) m_stall = 0;
    if (pause_set) m_pause = 1; else if (pause_clr) m_pause = 0;
    m_bank = pingpong_en ? (fifo_clr ? !m_bank : m_bank) : 1'b0;
    m_tog  = rstdt_set ? 1'b0 : (ev_pkt_ok ? !m_tog : m_tog);
    if (ev_bank_rx) m_pb = 1; else if (irq_ack) m_pb = 0;
    if (ev_nak) m_ph = 1; else if (irq_ack) m_ph = 0;
    e.tag = tag; e.bank = m_bank; e.tog = m_tog; e.stall = m_stall; e.pause = m_pause;
    e.irq = (m_pb || m_ph) && irq_en;
    if (!m_pause) e.dma = dma_want;
    else if (m_ph) e.dma = 1'b0;
    else if (m_pb) e.dma = dma_want && dma_busy;
    else e.dma = dma_want;
    sb_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    {fifo_clr, pause_set, pause_clr, stall_set, stall_clr, rstdt_set} = '0;
    {ev_bank_rx, ev_nak, ev_setup, ev_pkt_ok, irq_ack} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    dma_want = 1'b1;
    #1;
    // R1: reset state
    chk1("R1", "cur_bank", cur_bank[0], 1'b0);
    chk1("R1", "toggle", toggle, 1'b0);
    chk1("R1", "stall_req", stall_req, 1'b0);
    chk1("R1", "pause_en", pause_en, 1'b0);
    chk1("R1", "ep_irq", ep_irq, 1'b0);
    chk1("R1", "dma_req", dma_req, 1'b1);
    @(negedge clk);

    // R2: strobes, idle cycles, set wins
    stall_set = 1; cycle("R2 stall set");
    cycle("R2 idle hold");
    stall_clr = 1; cycle("R2 stall clr");
    stall_set = 1; stall_clr = 1; cycle("R2 both set wins");
    pause_set = 1; pause_clr = 1; cycle("R2 pause both");
    pause_clr = 1; cycle("R2 pause clr");

    // R3: bank pointer
    fifo_clr = 1; cycle("R3 single bank stays 0");
    pingpong_en = 1;
    fifo_clr = 1; cycle("R3 advance to 1");
    cycle("R3 hold");
    fifo_clr = 1; cycle("R3 wrap to 0");
    pingpong_en = 0; cycle("R3 single mode bank 0");
    pingpong_en = 1;

    // R7: events with pause off
    irq_en = 1;
    ev_nak = 1; cycle("R7 nak no pause");
    ev_bank_rx = 1; cycle("R7 bank no pause");
    irq_ack = 1; cycle("R11 ack clears");
    ev_bank_rx = 1; irq_ack = 1; cycle("R11 event beats ack");
    irq_ack = 1; cycle("R11 ack");

    // R4: nak under pause, busy, interrupt masked
    irq_en = 0;
    pause_set = 1; cycle("R4 pause on");
    dma_busy = 1;
    ev_nak = 1; cycle("R4 nak drops mid transfer");
    cycle("R4 still blocked");
    irq_ack = 1; cycle("R6 ack restores");

    // R5: bank event while busy
    ev_bank_rx = 1; cycle("R5 busy keeps request");
    cycle("R5 still busy");
    dma_busy = 0; cycle("R5 transfer done drops");
    dma_busy = 1; cycle("R5 no new bank request");
    dma_busy = 0;
    pause_clr = 1; cycle("R6 pause clr restores");
    irq_en = 1; cycle("R11 irq enabled shows pending");
    irq_ack = 1; cycle("R11 clear");

    // R9 / R8: toggle
    ev_pkt_ok = 1; cycle("R9 flip to 1");
    ev_nak = 1; cycle("R9 nak holds");
    irq_ack = 1; cycle("R9 idle holds");
    ev_pkt_ok = 1; cycle("R9 flip to 0");
    ev_pkt_ok = 1; cycle("R9 flip to 1 again");
    rstdt_set = 1; ev_pkt_ok = 1; cycle("R8 force beats flip");
    rstdt_set = 1; cycle("R8 force when already 0");

    // R10: SETUP against STALL
    stall_set = 1; cycle("R10 stall on");
    ev_setup = 1; cycle("R10 setup clears");
    stall_set = 1; ev_setup = 1; cycle("R10 set beats setup");
    ev_setup = 1; cycle("R10 setup clears again");

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule